// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

An 8-bit control and status register for a small microcontroller-style peripheral. Two of its bits switch two external timers on and off. Two other bits capture the overflow pulses that those timers send back. The remaining four bits condition two asynchronous interrupt pins. Each pin has its own mode bit that selects low-level or falling-edge sensing, and a request flag that records a detected interrupt.

The CPU reads and writes the register through a simple select/write-enable port. A write replaces the whole byte, so software can also set or clear the flags directly. The interrupt controller returns one acknowledge pulse per source. A timer flag is cleared by its acknowledge. A pin request flag is cleared by its acknowledge only in edge mode. In level mode the pin request flag simply mirrors the synchronized pin.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and both run outputs are 0.
- R2: Bit layout, MSB first: timer1 flag (7), timer1 run (6), timer0 flag (5), timer0 run (4), pin1 request (3), pin1 mode (2), pin0 request (1), pin0 mode (0). A cycle with sel_i and we_i both high loads all eight bits from wdata_i at the next edge, subject to R4, R7 and R9. rdata_o always shows the current value.
- R3: tmr_run_o[t] equals the run bit of timer t and changes only after a register write.
- R4: An overflow pulse on tmr_ovf_i[t] sets the timer t flag at the next edge. This set takes priority over an acknowledge or a software write of 0 in the same cycle.
- R5: An acknowledge on ack_tmr_i[t] with no overflow in the same cycle clears the timer t flag at the next edge.
- R6: Each pin passes through a two-flop synchronizer. A pin change driven before clock edge k reaches the request bit at edge k+2.
- R7: With the mode bit at 0 (level mode), the request bit equals the inverted synchronized pin in every cycle. Acknowledges and writes to it have no effect, and it is not held once the pin is high again.
- R8: With the mode bit at 1 (edge mode), a synchronized transition from 1 to 0 sets the request bit. A rising or steady pin does not set it.
- R9: In edge mode, ack_ext_i[x] clears request x and a write loads it. A falling edge in the same cycle takes priority over both.
- R10: In edge mode, a set request stays set after the pin returns high until it is acknowledged or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write enable, qualified by sel_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register value |
| tmr_ovf_i | input | 2 | Overflow pulses, one per timer |
| tmr_run_o | output | 2 | Run enables, one per timer |
| ext_pin_i | input | 2 | Asynchronous interrupt pins, idle high |
| ack_tmr_i | input | 2 | Timer interrupt acknowledges |
| ack_ext_i | input | 2 | Pin interrupt acknowledges |

## Verification
The assertions assume that overflow, acknowledge and write inputs are synchronous single-cycle events that are stable around the clock edge. They also assume the pins idle high during reset, so that no spurious falling edge is seen once reset is released. The bench drives every input, pins included, on the falling clock edge. This gives the synchronizer clean values, so the modelled three-edge latency is exact. Random phases freely mix mode changes, acknowledges, overflows and writes within those rules, so the priority cases arise in both modes.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NUM_TMR = 2;
  localparam int NUM_EXT = 2;
  localparam int REG_W   = 8;

  // bit positions decoded by software
  function automatic int tflag_pos(input int t);
    return 5 + 2 * t;
  endfunction
  function automatic int trun_pos(input int t);
    return 4 + 2 * t;
  endfunction
  function automatic int ereq_pos(input int e);
    return 1 + 2 * e;
  endfunction
  function automatic int emode_pos(input int e);
    return 2 * e;
  endfunction
endpackage

// File: rtl/tmr_irq_sync.sv
module tmr_irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_irq_tflag.sv
module tmr_irq_tflag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic ack_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (ovf_i) flag_o <= 1'b1;
    else if (ack_i) flag_o <= 1'b0;
    else if (wr_i)  flag_o <= wbit_i;
  end

  assert_tovf_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_o);
  assert_tack_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ovf_i) |=> !flag_o);
endmodule

// File: rtl/tmr_irq_ext.sv
module tmr_irq_ext #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic ack_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic req_o
);
  logic pin_s, prev_q, fall;

  tmr_irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_s;
  end

  assign fall = prev_q & ~pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           req_o <= 1'b0;
    else if (!edge_mode_i) req_o <= ~pin_s;
    else if (fall)         req_o <= 1'b1;
    else if (ack_i)        req_o <= 1'b0;
    else if (wr_i)         req_o <= wbit_i;
  end

  assert_level_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && !pin_s) |=> req_o);
  assert_level_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && pin_s) |=> !req_o);
  assert_edge_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && fall) |=> req_o);
  assert_edge_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && ack_i && !fall) |=> !req_o);
  assert_edge_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && req_o && !ack_i && !wr_i) |=> req_o);
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NUM_TMR-1:0] tmr_ovf_i,
  output logic [NUM_TMR-1:0] tmr_run_o,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic [NUM_TMR-1:0] ack_tmr_i,
  input  logic [NUM_EXT-1:0] ack_ext_i
);
  logic               wr;
  logic [NUM_TMR-1:0] run_q, tflag;
  logic [NUM_EXT-1:0] mode_q, ereq;

  assign wr = sel_i & we_i;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  run_q[t] <= 1'b0;
      else if (wr)  run_q[t] <= wdata_i[trun_pos(t)];
    end

    tmr_irq_tflag u_tflag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ovf_i (tmr_ovf_i[t]),
      .ack_i (ack_tmr_i[t]),
      .wr_i  (wr),
      .wbit_i(wdata_i[tflag_pos(t)]),
      .flag_o(tflag[t])
    );
  end

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mode_q[e] <= 1'b0;
      else if (wr)  mode_q[e] <= wdata_i[emode_pos(e)];
    end

    tmr_irq_ext #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (ext_pin_i[e]),
      .edge_mode_i(mode_q[e]),
      .ack_i      (ack_ext_i[e]),
      .wr_i       (wr),
      .wbit_i     (wdata_i[ereq_pos(e)]),
      .req_o      (ereq[e])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      rdata_o[tflag_pos(t)] = tflag[t];
      rdata_o[trun_pos(t)]  = run_q[t];
    end
    for (int e = 0; e < NUM_EXT; e++) begin
      rdata_o[ereq_pos(e)]  = ereq[e];
      rdata_o[emode_pos(e)] = mode_q[e];
    end
  end

  assign tmr_run_o = run_q;

  assert_run_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(tmr_run_o));
  assert_run_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (tmr_run_o == {$past(wdata_i[6]), $past(wdata_i[4])}));
endmodule

// File: tb/tmr_irq_ctrl_tb.sv
module tmr_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] tmr_ovf_i = '0, tmr_run_o, ack_tmr_i = '0, ack_ext_i = '0;
  logic [1:0] ext_pin_i = 2'b11;

  int n_chk = 0, n_fail = 0;
  bit done = 0, model_on = 0;

  always #5 clk_i = ~clk_i;

  tmr_irq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tmr_ovf_i(tmr_ovf_i),
    .tmr_run_o(tmr_run_o), .ext_pin_i(ext_pin_i), .ack_tmr_i(ack_tmr_i),
    .ack_ext_i(ack_ext_i)
  );

  // behavioural reference: pin history queues, [0]=3 edges ago, [2]=last edge
  bit [7:0] m;
  bit hq0[$], hq1[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m = 8'h00;
      hq0 = '{1'b1, 1'b1, 1'b1};
      hq1 = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit [7:0] nx;
      bit w, s, pv;
      w = sel_i && we_i;
      nx = m;
      if (w) begin nx[6] = wdata_i[6]; nx[4] = wdata_i[4]; nx[2] = wdata_i[2]; nx[0] = wdata_i[0]; end
      for (int t = 0; t < 2; t++) begin
        int p;
        p = (t == 1) ? 7 : 5;
        if (tmr_ovf_i[t]) nx[p] = 1;
        else if (ack_tmr_i[t]) nx[p] = 0;
        else if (w) nx[p] = wdata_i[p];
      end
      for (int e = 0; e < 2; e++) begin
        int rq, md;
        rq = (e == 1) ? 3 : 1;
        md = (e == 1) ? 2 : 0;
        s  = (e == 1) ? hq1[1] : hq0[1];
        pv = (e == 1) ? hq1[0] : hq0[0];
        if (!m[md]) nx[rq] = !s;
        else if (pv && !s) nx[rq] = 1;
        else if (ack_ext_i[e]) nx[rq] = 0;
        else if (w) nx[rq] = wdata_i[rq];
      end
      hq0.push_back(ext_pin_i[0]); void'(hq0.pop_front());
      hq1.push_back(ext_pin_i[1]); void'(hq1.pop_front());
      m = nx;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (model_on && rst_ni) begin
      chk("R4", {rdata_o[7], rdata_o[5]}, {m[7], m[5]});
      chk("R2", {rdata_o[6], rdata_o[4], rdata_o[2], rdata_o[0]}, {m[6], m[4], m[2], m[0]});
      chk("R3", tmr_run_o, {m[6], m[4]});
      chk(m[0] ? "R9" : "R7", rdata_o[1], m[1]);
      chk(m[2] ? "R9" : "R7", rdata_o[3], m[3]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] v);
    sel_i = 1; we_i = 1; wdata_i = v;
    cyc(1);
    sel_i = 0; we_i = 0;
  endtask

  initial begin : main
    cyc(3);
    rst_ni = 1;
    cyc(1);
    chk("R1", rdata_o, 8'h00);
    chk("R1", tmr_run_o, 2'b00);
    model_on = 1;

    wr(8'h50);
    chk("R3", tmr_run_o, 2'b11);
    tmr_ovf_i = 2'b01; cyc(1); tmr_ovf_i = 0;
    chk("R4", rdata_o, 8'h70);
    ack_tmr_i = 2'b01; cyc(1); ack_tmr_i = 0;
    chk("R5", rdata_o, 8'h50);
    tmr_ovf_i = 2'b10; sel_i = 1; we_i = 1; wdata_i = 8'h50; cyc(1);
    tmr_ovf_i = 0; sel_i = 0; we_i = 0;
    chk("R4", rdata_o, 8'hD0);
    tmr_ovf_i = 2'b10; ack_tmr_i = 2'b10; cyc(1); tmr_ovf_i = 0; ack_tmr_i = 0;
    chk("R4", rdata_o, 8'hD0);
    ack_tmr_i = 2'b10; cyc(1); ack_tmr_i = 0;
    chk("R5", rdata_o, 8'h50);

    wr(8'h05);
    chk("R2", rdata_o, 8'h05);
    chk("R3", tmr_run_o, 2'b00);
    ext_pin_i[0] = 0; cyc(2);
    chk("R6", rdata_o, 8'h05);
    cyc(1);
    chk("R8", rdata_o, 8'h07);
    ext_pin_i[0] = 1; cyc(5);
    chk("R10", rdata_o, 8'h07);
    ack_ext_i = 2'b01; cyc(1); ack_ext_i = 0;
    chk("R9", rdata_o, 8'h05);
    cyc(5);
    chk("R8", rdata_o, 8'h05);
    wr(8'h0F);
    chk("R9", rdata_o, 8'h0F);
    wr(8'h05);
    chk("R9", rdata_o, 8'h05);
    ext_pin_i[0] = 0; cyc(2);
    ack_ext_i = 2'b01; cyc(1); ack_ext_i = 0;
    chk("R9", rdata_o, 8'h07);
    ext_pin_i[0] = 1; ack_ext_i = 2'b01; cyc(1); ack_ext_i = 0;
    chk("R9", rdata_o, 8'h05);

    wr(8'h01);
    ext_pin_i[1] = 0; cyc(3);
    chk("R7", rdata_o, 8'h09);
    ack_ext_i = 2'b10; cyc(1); ack_ext_i = 0;
    chk("R7", rdata_o, 8'h09);
    wr(8'h01);
    chk("R7", rdata_o, 8'h09);
    ext_pin_i[1] = 1; cyc(3);
    chk("R7", rdata_o, 8'h01);

    for (int i = 0; i < 4000; i++) begin
      tmr_ovf_i = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
      ack_tmr_i = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
      ack_ext_i = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
      if ($urandom_range(0, 5) == 0) ext_pin_i[0] = ~ext_pin_i[0];
      if ($urandom_range(0, 5) == 0) ext_pin_i[1] = ~ext_pin_i[1];
      if ($urandom_range(0, 9) == 0) begin
        sel_i = 1; we_i = 1; wdata_i = 8'($urandom);
      end else begin
        sel_i = $urandom_range(0, 1); we_i = 0;
      end
      cyc(1);
    end
    sel_i = 0; we_i = 0; tmr_ovf_i = 0; ack_tmr_i = 0; ack_ext_i = 0;
    cyc(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule